// File: doc/BRIEF.md
# Sticky Interrupt Aggregator with Write-One-to-Clear Status

This block collects single-cycle or level event pulses from peripherals into sticky status bits and turns them into interrupt requests for a processor. Three independent groups live behind one small register bus. The main group has a full-width status register and a separate enable mask. The packed group keeps 16 status bits and their 16 enables in one word. The flag group has no mask and raises its request while any flag is set.

Software acknowledges an event by writing a one to its status bit. Writing a zero leaves that bit alone. A new event that arrives in the same cycle as its clear wins, so no edge is lost. Each request output is a register that is recomputed every cycle, so a request rises or falls one clock after the state that causes it. Read data is also registered and arrives one cycle after the read address.

Top module: `irq_agg`

## Requirements
- R1: An event input that is high at a clock edge sets the matching status bit in its group (main, packed or flag). The bit then stays set until software clears it.
- R2: A write to address 0 clears exactly those main status bits that are one in wr_data. All other main status bits keep their value.
- R3: When an event sets a bit in the same cycle that a write clears it, the bit ends up set. This holds in all three groups.
- R4: A write to address 1 replaces the whole main mask with wr_data. A read of address 1 returns the mask.
- R5: irq_main is high in the cycle after (main status AND main mask) is nonzero. It is low in the cycle after that AND is zero.
- R6: A read of address 2 returns the packed word, with status in bits [15:0] and mask in bits [31:16]. A write to address 2 clears the packed status bits that are one in wr_data[15:0] and leaves the packed mask unchanged.
- R7: A write to address 3 loads the packed mask from wr_data[31:16] and leaves the packed status unchanged. A read of address 3 returns the same packed word as address 2.
- R8: irq_pack is high in the cycle after (packed status AND packed mask) is nonzero, and low otherwise.
- R9: Address 4 holds the flags in its low FLAG_W bits and clears them on write-one. irq_flag is high in the cycle after any flag is set. It drops in the cycle after the whole flag register becomes zero.
- R10: A synchronous reset clears all status, mask and flag bits, all requests and rd_data. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R11: rd_data shows the register selected by rd_addr one cycle after that address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_main | input | DATA_W | Event inputs of the main group |
| ev_pack | input | DATA_W/2 | Event inputs of the packed group |
| ev_flag | input | FLAG_W | Event inputs of the flag group |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | DATA_W | Registered read data |
| irq_main | output | 1 | Request of the main group |
| irq_pack | output | 1 | Request of the packed group |
| irq_flag | output | 1 | Request of the flag group |

## Verification
The checker looks at every cycle for four things. It checks that clears remove only the written ones while events still set their bits. It checks that a mask write lands exactly and that a packed status write leaves the packed mask alone. It also checks that each request follows its masked status with one cycle of delay. Other behaviours are shown only by the bench's sweeps: the exact bit positions inside the packed word, the zero reads and ignored writes at unmapped addresses, the read latency, and the reset state seen through the bus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    SEL_MAIN_ST  = 3'd0,
    SEL_MAIN_MSK = 3'd1,
    SEL_PACK     = 3'd2,
    SEL_PACK_MSK = 3'd3,
    SEL_FLAG     = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_eff) | set_i;  // set wins over clear
  end
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/req_reg.sv
module req_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] vec,
  input  logic [W-1:0] en,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(vec & en);
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    ev_main,
  input  logic [DATA_W/2-1:0]  ev_pack,
  input  logic [FLAG_W-1:0]    ev_flag,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_main,
  output logic                 irq_pack,
  output logic                 irq_flag
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] st_main, msk_main;
  logic [HALF_W-1:0] st_pack, msk_pack;
  logic [FLAG_W-1:0] st_flag;

  logic wr_main_st, wr_main_msk, wr_pack_st, wr_pack_msk, wr_flag;
  assign wr_main_st  = wr_en && (wr_addr == SEL_MAIN_ST);
  assign wr_main_msk = wr_en && (wr_addr == SEL_MAIN_MSK);
  assign wr_pack_st  = wr_en && (wr_addr == SEL_PACK);
  assign wr_pack_msk = wr_en && (wr_addr == SEL_PACK_MSK);
  assign wr_flag     = wr_en && (wr_addr == SEL_FLAG);

  sticky_bank #(.W(DATA_W)) u_st_main (
    .clk(clk), .rst(rst), .set_i(ev_main), .clr_en(wr_main_st),
    .clr_i(wr_data), .q(st_main));

  sticky_bank #(.W(HALF_W)) u_st_pack (
    .clk(clk), .rst(rst), .set_i(ev_pack), .clr_en(wr_pack_st),
    .clr_i(wr_data[HALF_W-1:0]), .q(st_pack));

  sticky_bank #(.W(FLAG_W)) u_st_flag (
    .clk(clk), .rst(rst), .set_i(ev_flag), .clr_en(wr_flag),
    .clr_i(wr_data[FLAG_W-1:0]), .q(st_flag));

  mask_reg #(.W(DATA_W)) u_msk_main (
    .clk(clk), .rst(rst), .we(wr_main_msk), .d(wr_data), .q(msk_main));

  mask_reg #(.W(HALF_W)) u_msk_pack (
    .clk(clk), .rst(rst), .we(wr_pack_msk), .d(wr_data[DATA_W-1:HALF_W]),
    .q(msk_pack));

  req_reg #(.W(DATA_W)) u_req_main (
    .clk(clk), .rst(rst), .vec(st_main), .en(msk_main), .irq(irq_main));

  req_reg #(.W(HALF_W)) u_req_pack (
    .clk(clk), .rst(rst), .vec(st_pack), .en(msk_pack), .irq(irq_pack));

  req_reg #(.W(FLAG_W)) u_req_flag (
    .clk(clk), .rst(rst), .vec(st_flag), .en({FLAG_W{1'b1}}), .irq(irq_flag));

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rd_addr)
      SEL_MAIN_ST:  rd_next = st_main;
      SEL_MAIN_MSK: rd_next = msk_main;
      SEL_PACK,
      SEL_PACK_MSK: rd_next = {msk_pack, st_pack};
      SEL_FLAG:     rd_next[FLAG_W-1:0] = st_flag;
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [DATA_W-1:0]   ev_main,
  input logic                wr_en,
  input logic [2:0]          wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [DATA_W-1:0]   st_main,
  input logic [DATA_W-1:0]   msk_main,
  input logic [DATA_W/2-1:0] st_pack,
  input logic [DATA_W/2-1:0] msk_pack,
  input logic [FLAG_W-1:0]   st_flag,
  input logic                irq_main,
  input logic                irq_pack,
  input logic                irq_flag
);
  assert_clear_exact_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0) |=> st_main == (($past(st_main) & ~$past(wr_data)) | $past(ev_main)));

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (|ev_main) |=> ((st_main & $past(ev_main)) == $past(ev_main)));

  assert_mask_load_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd1) |=> msk_main == $past(wr_data));

  assert_irq_up_R5: assert property (@(posedge clk) disable iff (rst)
    (|(st_main & msk_main)) |=> irq_main);

  assert_irq_down_R5: assert property (@(posedge clk) disable iff (rst)
    !(|(st_main & msk_main)) |=> !irq_main);

  assert_pack_mask_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd2) |=> $stable(msk_pack));

  assert_pack_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (|(st_pack & msk_pack)) |=> irq_pack);

  assert_flag_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (st_flag == '0) |=> !irq_flag);
endmodule

bind irq_agg irq_agg_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rst(rst), .ev_main(ev_main), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .st_main(st_main), .msk_main(msk_main), .st_pack(st_pack),
  .msk_pack(msk_pack), .st_flag(st_flag), .irq_main(irq_main),
  .irq_pack(irq_pack), .irq_flag(irq_flag));

// File: tb/irq_agg_test.sv
`timescale 1ns/1ps
module irq_agg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ev_main = '0;
  logic [15:0] ev_pack = '0;
  logic [7:0]  ev_flag = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_main, irq_pack, irq_flag;

  int errors = 0;
  int checks = 0;

  // model
  logic [31:0] m_st = '0, m_msk = '0;
  logic [15:0] m_pst = '0, m_pmsk = '0;
  logic [7:0]  m_fl = '0;

  always #4 clk = ~clk;

  irq_agg uut (
    .clk(clk), .rst(rst), .ev_main(ev_main), .ev_pack(ev_pack), .ev_flag(ev_flag),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_main(irq_main), .irq_pack(irq_pack), .irq_flag(irq_flag));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_st;
      3'd1: return m_msk;
      3'd2, 3'd3: return {m_pmsk, m_pst};
      3'd4: return {24'd0, m_fl};
      default: return 32'd0;
    endcase
  endfunction

  // one clock with given stimulus; checks rd_data and all requests afterwards
  task automatic step(input string tag, input logic [31:0] em, input logic [15:0] ep,
                      input logic [7:0] ef, input logic we, input logic [2:0] wa,
                      input logic [31:0] wd, input logic [2:0] ra);
    logic [31:0] e_rd;
    logic e_im, e_ip, e_if;
    ev_main = em; ev_pack = ep; ev_flag = ef;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    e_rd = model_rd(ra);
    e_im = |(m_st & m_msk);
    e_ip = |(m_pst & m_pmsk);
    e_if = |m_fl;
    m_st = (m_st & ~((we && wa == 3'd0) ? wd : 32'd0)) | em;
    if (we && wa == 3'd1) m_msk = wd;
    m_pst = (m_pst & ~((we && wa == 3'd2) ? wd[15:0] : 16'd0)) | ep;
    if (we && wa == 3'd3) m_pmsk = wd[31:16];
    m_fl = (m_fl & ~((we && wa == 3'd4) ? wd[7:0] : 8'd0)) | ef;
    #2;
    chk(tag, "rd_data", rd_data, e_rd);
    chk(tag, "irq_main", {31'd0, irq_main}, {31'd0, e_im});
    chk(tag, "irq_pack", {31'd0, irq_pack}, {31'd0, e_ip});
    chk(tag, "irq_flag", {31'd0, irq_flag}, {31'd0, e_if});
    ev_main = '0; ev_pack = '0; ev_flag = '0; wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, '0, '0, '0, 1'b0, 3'd0, '0, a);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d);
    step(tag, '0, '0, '0, 1'b1, a, d, 3'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R10: reset state through the bus
    for (int a = 0; a < 8; a++) rd("R10", 3'(a));
    // R1: walk each event bit into each group
    for (int i = 0; i < 32; i++) step("R1", 32'd1 << i, '0, '0, 1'b0, 3'd0, '0, 3'd0);
    for (int i = 0; i < 16; i++) step("R1", '0, 16'd1 << i, '0, 1'b0, 3'd0, '0, 3'd2);
    for (int i = 0; i < 8; i++)  step("R1", '0, '0, 8'd1 << i, 1'b0, 3'd0, '0, 3'd4);
    rd("R1", 3'd0); rd("R11", 3'd2); rd("R11", 3'd4);
    // R2: partial clears
    wr("R2", 3'd0, 32'h0000_FFFF); rd("R2", 3'd0);
    wr("R2", 3'd0, 32'hA5A5_0000); rd("R2", 3'd0);
    wr("R2", 3'd0, 32'h0000_0000); rd("R2", 3'd0);
    wr("R2", 3'd0, 32'hFFFF_FFFF); rd("R2", 3'd0);
    // R3: set beats clear in every group
    step("R3", 32'h0000_0008, '0, '0, 1'b1, 3'd0, 32'hFFFF_FFFF, 3'd0); rd("R3", 3'd0);
    step("R3", '0, 16'h0100, '0, 1'b1, 3'd2, 32'h0000_FFFF, 3'd2); rd("R3", 3'd2);
    step("R3", '0, '0, 8'h04, 1'b1, 3'd4, 32'h0000_00FF, 3'd4); rd("R3", 3'd4);
    // R4, R5: mask walk against a fixed status pattern
    step("R5", 32'h0F0F_0F0F, '0, '0, 1'b0, 3'd0, '0, 3'd0);
    for (int i = 0; i < 32; i++) begin
      wr("R4", 3'd1, 32'd1 << i);
      rd("R4", 3'd1);
      rd("R5", 3'd1);
    end
    wr("R4", 3'd1, 32'hFFFF_FFFF); rd("R5", 3'd1);
    wr("R5", 3'd0, 32'h0F0F_0F0F); rd("R5", 3'd0); rd("R5", 3'd0);
    // R6, R7, R8: packed word
    for (int i = 0; i < 16; i++) begin
      wr("R7", 3'd3, (32'd1 << (i + 16)) | 32'h0000_FFFF);
      rd("R7", 3'd3);
      rd("R8", 3'd2);
    end
    wr("R7", 3'd3, 32'h8001_0000); rd("R7", 3'd2);
    wr("R6", 3'd2, 32'hFFFF_00FF); rd("R6", 3'd2); rd("R8", 3'd2);
    wr("R6", 3'd2, 32'h0000_FF00); rd("R6", 3'd2); rd("R8", 3'd2);
    // R9: flags cleared one by one, request drops only at zero
    step("R9", '0, '0, 8'hFF, 1'b0, 3'd0, '0, 3'd4);
    for (int i = 0; i < 8; i++) begin
      wr("R9", 3'd4, 32'd1 << i);
      rd("R9", 3'd4);
      rd("R9", 3'd4);
    end
    // R10: unmapped writes ignored
    step("R10", 32'h1234_5678, 16'h00F0, 8'h3C, 1'b0, 3'd0, '0, 3'd0);
    wr("R4", 3'd1, 32'h0000_FF00);
    for (int a = 5; a < 8; a++) wr("R10", 3'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) rd("R10", 3'(a));
    // R10: reset clears everything
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    rst = 1'b0;
    m_st = '0; m_msk = '0; m_pst = '0; m_pmsk = '0; m_fl = '0;
    chk("R10", "irq_main", {31'd0, irq_main}, 32'd0);
    chk("R10", "irq_flag", {31'd0, irq_flag}, 32'd0);
    for (int a = 0; a < 8; a++) rd("R10", 3'(a));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule